// File: doc/BRIEF.md
# Deprecated-usage exception detector

This block watches instruction decode flags from a CPU pipeline and raises an exception request when software uses an operation that later cores will drop. It flags three patterns. The first is an instruction other than a no-op placed in the delay slot of a return-from-exception. The second is a sleep instruction placed in the delay slot of a branch. The third is an associative write into the memory-mapped instruction or operand cache arrays. The two delay-slot patterns raise a slot-illegal request. The cache-array pattern raises a data-address-error request.

Software turns each check off by setting its bit in a 32-bit disable mask, which is written and read through a single-cycle register port. Two copies of the mask are kept. The pending copy takes bus writes and is returned on reads. The active copy drives the checks, and it loads from the pending copy only on a cycle where a return-from-exception or an instruction-cache-invalidate instruction executes. Software can therefore depend on a new mask being in force only after one of those two instructions. The decoder, the cache arrays and exception vectoring lie outside the block, and their results arrive as input flags.

Top module: `legacy_use_trap`

## Requirements
- R1: After reset, both copies of the mask hold 0x0000_0013, a read returns 0x0000_0013, and neither request output is asserted.
- R2: A write with `bus_we` high and `bus_addr` equal to `REG_ADDR` stores only bits 0, 1 and 4 of `bus_wdata` into the pending mask. All other bits read as 0. `bus_rdata` shows the pending mask while `bus_addr` equals `REG_ADDR` and 0 at any other address. Writes to any other address leave the mask unchanged.
- R3: When `insn_valid`, `in_rte_slot` and active mask bit 0 is 0, and `slot_insn_nop` is 0, `slot_illegal_req` is 1 in the following cycle.
- R4: When `insn_valid`, `in_branch_slot` and `slot_insn_sleep` are all 1 and active mask bit 1 is 0, `slot_illegal_req` is 1 in the following cycle.
- R5: When `insn_valid` and `cache_array_assoc_wr` are both 1 and active mask bit 4 is 0, `addr_error_req` is 1 in the following cycle.
- R6: The active mask changes only at a clock edge where `rte_exec` or `icbi_exec` is 1, and it then takes the pending value held before that edge. A write in the same cycle as a strobe therefore takes effect only at a later strobe.
- R7: While `insn_valid` is 0, neither request is raised in the following cycle, whatever the other flags are.
- R8: Each request is a one-cycle pulse for each flagged instruction. If both delay-slot checks fire together, `slot_illegal_req` is still asserted for a single cycle.
- R9: Each mask bit suppresses only its own check, so the other checks keep working under any mix of bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Word-aligned byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data: the pending mask, or 0 at other addresses |
| insn_valid | input | 1 | The decode flags below belong to a real instruction this cycle |
| in_rte_slot | input | 1 | The instruction sits in a return-from-exception delay slot |
| slot_insn_nop | input | 1 | The instruction is a no-op |
| in_branch_slot | input | 1 | The instruction sits in a branch delay slot |
| slot_insn_sleep | input | 1 | The instruction is a sleep |
| cache_array_assoc_wr | input | 1 | The instruction performs an associative write to a memory-mapped cache array |
| rte_exec | input | 1 | A return-from-exception executes this cycle |
| icbi_exec | input | 1 | An instruction-cache-invalidate executes this cycle |
| slot_illegal_req | output | 1 | Slot-illegal exception request pulse |
| addr_error_req | output | 1 | Data-address-error exception request pulse |

## Verification
The checks are driven with each violating pattern on its own, and with near-miss patterns that differ by one flag. The near misses are a no-op in the return slot, a non-sleep instruction in a branch slot, and a flagged instruction with the valid bit low. Together these show that every qualifying term is really decoded. Mask values that turn off one check at a time show that each bit gates only its own path. Writes without a strobe, followed by a strobe, show the active copy lagging behind the pending one. A write issued in the same cycle as a strobe shows which pending value the active copy captures.

// File: rtl/legacy_use_trap.sv
module legacy_use_trap #(
  parameter int AW = 8,
  parameter logic [AW-1:0] REG_ADDR = 8'h0C,
  parameter logic [31:0] WR_BITS = 32'h0000_0013
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          insn_valid,
  input  logic          in_rte_slot,
  input  logic          slot_insn_nop,
  input  logic          in_branch_slot,
  input  logic          slot_insn_sleep,
  input  logic          cache_array_assoc_wr,
  input  logic          rte_exec,
  input  logic          icbi_exec,
  output logic          slot_illegal_req,
  output logic          addr_error_req
);
  localparam int B_RTE = 0;
  localparam int B_SLP = 1;
  localparam int B_CAW = 4;

  logic [31:0] pend_q, act_q;
  logic hit, commit, rte_bad, slp_bad, caw_bad;

  assign hit    = bus_addr == REG_ADDR;
  assign commit = rte_exec | icbi_exec;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q <= WR_BITS;
      act_q  <= WR_BITS;
    end else begin
      if (bus_we && hit) pend_q <= bus_wdata & WR_BITS;
      if (commit)        act_q  <= pend_q;
    end

  assign bus_rdata = hit ? pend_q : 32'h0;

  assign rte_bad = in_rte_slot & ~slot_insn_nop & ~act_q[B_RTE];
  assign slp_bad = in_branch_slot & slot_insn_sleep & ~act_q[B_SLP];
  assign caw_bad = cache_array_assoc_wr & ~act_q[B_CAW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      slot_illegal_req <= 1'b0;
      addr_error_req   <= 1'b0;
    end else begin
      slot_illegal_req <= insn_valid & (rte_bad | slp_bad);
      addr_error_req   <= insn_valid & caw_bad;
    end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~WR_BITS) == 32'h0);
  assert_rte_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && in_rte_slot && !slot_insn_nop && !act_q[B_RTE] |=> slot_illegal_req);
  assert_branch_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && in_branch_slot && slot_insn_sleep && !act_q[B_SLP] |=> slot_illegal_req);
  assert_cache_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && cache_array_assoc_wr && !act_q[B_CAW] |=> addr_error_req);
  assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rte_exec && !icbi_exec |=> $stable(act_q));
  assert_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> !slot_illegal_req && !addr_error_req);
endmodule

// File: tb/tb_legacy_use_trap.sv
module tb_legacy_use_trap;
  logic clk = 0, rst_n = 0;
  logic bus_we = 0;
  logic [7:0] bus_addr = 8'h0C;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic insn_valid = 0, in_rte_slot = 0, slot_insn_nop = 0, in_branch_slot = 0;
  logic slot_insn_sleep = 0, cache_array_assoc_wr = 0, rte_exec = 0, icbi_exec = 0;
  logic slot_illegal_req, addr_error_req;
  int checks = 0, failures = 0;
  bit done = 0;

  localparam logic [7:0] RA = 8'h0C;

  legacy_use_trap dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); bus_addr = a; #1;
    chk(req, bus_rdata, exp);
    bus_addr = RA;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, bit rte = 0, bit icbi = 0);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d; rte_exec = rte; icbi_exec = icbi;
    @(negedge clk);
    bus_we = 0; bus_addr = RA; rte_exec = 0; icbi_exec = 0;
  endtask

  task automatic commit(bit use_rte);
    @(negedge clk); rte_exec = use_rte; icbi_exec = !use_rte;
    @(negedge clk); rte_exec = 0; icbi_exec = 0;
  endtask

  // one instruction, then check the pulse and its end
  task automatic insn(string req, bit v, bit rs, bit nop, bit bs, bit slp, bit cw,
                      bit exp_sl, bit exp_ae);
    @(negedge clk);
    insn_valid = v; in_rte_slot = rs; slot_insn_nop = nop;
    in_branch_slot = bs; slot_insn_sleep = slp; cache_array_assoc_wr = cw;
    @(posedge clk); #1;
    chk({req, " slot"}, slot_illegal_req, exp_sl);
    chk({req, " dae"}, addr_error_req, exp_ae);
    @(negedge clk);
    insn_valid = 0; in_rte_slot = 0; slot_insn_nop = 0;
    in_branch_slot = 0; slot_insn_sleep = 0; cache_array_assoc_wr = 0;
    @(posedge clk); #1;
    chk({req, " pulse end R8"}, {slot_illegal_req, addr_error_req}, 0);
  endtask

  task automatic t_reset();
    rd("R1 reset read", RA, 32'h13);
    chk("R1 reset outputs", {slot_illegal_req, addr_error_req}, 0);
    insn("R1 all masked", 1, 1, 0, 1, 1, 1, 0, 0);
  endtask

  task automatic t_regs();
    wr(RA, 32'hFFFF_FFFF);
    rd("R2 reserved bits read 0", RA, 32'h13);
    wr(RA, 32'h0000_00EC);
    rd("R2 only bits 0,1,4 stored", RA, 32'h0);
    wr(8'h10, 32'h13);
    rd("R2 other address write ignored", RA, 32'h0);
    rd("R2 other address reads 0", 8'h10, 32'h0);
  endtask

  task automatic t_commit();
    insn("R6 old mask still active", 1, 1, 0, 0, 0, 0, 0, 0);
    commit(0);
    insn("R6 after icbi", 1, 1, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_checks();
    insn("R3 rte slot non-nop", 1, 1, 0, 0, 0, 0, 1, 0);
    insn("R3 rte slot nop", 1, 1, 1, 0, 0, 0, 0, 0);
    insn("R4 branch slot sleep", 1, 0, 0, 1, 1, 0, 1, 0);
    insn("R4 branch slot non-sleep", 1, 0, 0, 1, 0, 0, 0, 0);
    insn("R4 sleep outside slot", 1, 0, 0, 0, 1, 0, 0, 0);
    insn("R5 cache array write", 1, 0, 0, 0, 0, 1, 0, 1);
    insn("R7 invalid ignored", 0, 1, 0, 1, 1, 1, 0, 0);
    insn("R8 both slot checks", 1, 1, 0, 1, 1, 0, 1, 0);
    insn("R5 R3 together", 1, 1, 0, 0, 0, 1, 1, 1);
  endtask

  task automatic t_independent();
    wr(RA, 32'h01); commit(1);
    insn("R9 bit0 off rte", 1, 1, 0, 0, 0, 0, 0, 0);
    insn("R9 bit0 off sleep", 1, 0, 0, 1, 1, 0, 1, 0);
    insn("R9 bit0 off cache", 1, 0, 0, 0, 0, 1, 0, 1);
    wr(RA, 32'h12); commit(1);
    insn("R9 bits1,4 off rte", 1, 1, 0, 0, 0, 0, 1, 0);
    insn("R9 bits1,4 off sleep", 1, 0, 0, 1, 1, 0, 0, 0);
    insn("R9 bits1,4 off cache", 1, 0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_same_cycle();
    wr(RA, 32'h0); commit(0);
    wr(RA, 32'h13, 1, 0);
    rd("R6 pending updated", RA, 32'h13);
    insn("R6 same-cycle write not active", 1, 0, 0, 0, 0, 1, 0, 1);
    commit(1);
    insn("R6 later strobe applies", 1, 0, 0, 0, 0, 1, 0, 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_commit();
    t_checks();
    t_independent();
    t_same_cycle();
    finish_up();
  end
endmodule